// File: doc/BRIEF.md
# Dual Clock Generator Control Registers

This block is the software-facing register file for two clock generators. Each generator has three divider/multiplier count registers (N, M, K, each holding an encoded value) and a control word that carries an enable bit and a lock-window field. One shared register selects, for each generator, whether its clock is taken from the reference (bypass) or from the generator output. A read-only status word reports the live lock inputs, sticky lock-changed flags and the not-bypassed state of each generator.

Software programs a generator by first putting it in bypass. It then loads the counts and the window, releases bypass, and waits for lock, lock-changed and not-bypassed. Last, it writes 1 to the lock-changed flag to clear it. The block exports the bypass selects, enables, windows and counts to the clock muxes and the analog generators, which lie outside this block. Accesses use a single-cycle write strobe and a combinational read path addressed by byte offset. Address bits 1:0 are ignored.

Top module: `clkgen_regs`

## Requirements
- R1: Word offsets are 0x00, 0x04 and 0x08 for generator A's N, M and K counts, and 0x0C for A's control word. Generator B uses 0x10, 0x14, 0x18 and 0x1C in the same order. Counts are 19 bits wide, read back zero-extended, and reset to 0x40000.
- R2: Each control word resets to 0x1A04 and reads back the low 16 bits written. Bit 0 drives the generator's enable output and bits 6:4 drive its lock-window output, so the generator leaves reset disabled with window code 0.
- R3: After reset both generators are bypassed, and the derive register at 0x20 reads 0x3010.
- R4: A write to 0x20 takes effect only if its value is 0x0010, 0x1010, 0x2010 or 0x3010. Bit 12 sets bypass for A and bit 13 sets bypass for B. Writes with any other value leave the bypass state unchanged.
- R5: The status word at 0x24 reads as follows. Bit 0 is A's lock input and bit 1 is B's, both live. Bits 4 and 5 are 1 when A and B respectively are not bypassed. Bits 31:6 are zero.
- R6: Status bits 2 (A) and 3 (B) become 1 on the clock edge after the lock input of that generator changes level in either direction.
- R7: Writing 1 to status bit 2 or 3 clears that flag. Writing 0 to either bit, or writing any other status bit, has no effect. If a lock change occurs in the same cycle as the clear, the flag stays set.
- R8: A write to a generator's N, M or K register is ignored while that generator is not bypassed.
- R9: Reads of offsets 0x28 to 0x3C return zero.
- R10: The count outputs of each generator always equal its count registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the addressed word |
| addr | input | 6 | Byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for addr (combinational) |
| lock_a | input | 1 | Lock indication from generator A |
| lock_b | input | 1 | Lock indication from generator B |
| byp_a | output | 1 | Generator A bypass select |
| byp_b | output | 1 | Generator B bypass select |
| en_a | output | 1 | Generator A enable |
| en_b | output | 1 | Generator B enable |
| win_a | output | 3 | Generator A lock-window code |
| win_b | output | 3 | Generator B lock-window code |
| n_a | output | 19 | Generator A N count |
| m_a | output | 19 | Generator A M count |
| k_a | output | 19 | Generator A K count |
| n_b | output | 19 | Generator B N count |
| m_b | output | 19 | Generator B M count |
| k_b | output | 19 | Generator B K count |

## Verification
A corrupted bypass bit shows at once in three places: the bypass output, the derive readback and the not-bypassed status bits, all in the same cycle. A count write that the bypass rule should have refused shows on the count outputs one edge later. A lost or stuck lock-changed flag shows on the first status read after the edge that follows the lock transition. The bench therefore reads status right after each lock toggle and right after each clear, including a clear that races a new lock change.

// File: rtl/clkgen_regs.sv
module clkgen_regs #(
  parameter int CNT_W = 19,
  parameter int AW = 6,
  parameter logic [CNT_W-1:0] CNT_RST = 19'h40000,
  parameter logic [15:0] CTRL_RST = 16'h1A04
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [AW-1:0]    addr,
  input  logic [31:0]      wdata,
  output logic [31:0]      rdata,
  input  logic             lock_a,
  input  logic             lock_b,
  output logic             byp_a,
  output logic             byp_b,
  output logic             en_a,
  output logic             en_b,
  output logic [2:0]       win_a,
  output logic [2:0]       win_b,
  output logic [CNT_W-1:0] n_a,
  output logic [CNT_W-1:0] m_a,
  output logic [CNT_W-1:0] k_a,
  output logic [CNT_W-1:0] n_b,
  output logic [CNT_W-1:0] m_b,
  output logic [CNT_W-1:0] k_b
);
  localparam int IW = AW - 2;
  localparam logic [IW-1:0] DERIVE_IDX = IW'(8);
  localparam logic [IW-1:0] STATUS_IDX = IW'(9);

  logic [CNT_W-1:0] cnt [2][3];
  logic [15:0]      ctrl [2];
  logic [1:0]       byp, lock_q, chg;
  logic [IW-1:0]    widx;
  logic [1:0]       lock;
  logic             unused_addr;

  assign widx = addr[AW-1:2];
  assign lock = {lock_b, lock_a};
  assign unused_addr = &{1'b0, addr[1:0]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byp    <= 2'b11;
      lock_q <= 2'b00;
      chg    <= 2'b00;
      for (int g = 0; g < 2; g++) begin
        ctrl[g] <= CTRL_RST;
        for (int r = 0; r < 3; r++) cnt[g][r] <= CNT_RST;
      end
    end else begin
      lock_q <= lock;
      for (int g = 0; g < 2; g++) begin
        for (int r = 0; r < 3; r++)
          if (wr_en && widx == IW'(4*g + r) && byp[g])
            cnt[g][r] <= wdata[CNT_W-1:0];
        if (wr_en && widx == IW'(4*g + 3))
          ctrl[g] <= wdata[15:0];
        chg[g] <= (lock[g] ^ lock_q[g]) |
                  (chg[g] & ~(wr_en && widx == STATUS_IDX && wdata[2+g]));
      end
      if (wr_en && widx == DERIVE_IDX && (wdata & ~32'h3000) == 32'h0010)
        byp <= wdata[13:12];
    end
  end

  always_comb begin
    rdata = '0;
    if (widx < IW'(8)) begin
      case (widx[1:0])
        2'd0:    rdata[CNT_W-1:0] = cnt[widx[2]][0];
        2'd1:    rdata[CNT_W-1:0] = cnt[widx[2]][1];
        2'd2:    rdata[CNT_W-1:0] = cnt[widx[2]][2];
        default: rdata[15:0]      = ctrl[widx[2]];
      endcase
    end else if (widx == DERIVE_IDX) begin
      rdata = {18'b0, byp, 12'h010};
    end else if (widx == STATUS_IDX) begin
      rdata = {26'b0, ~byp, chg, lock};
    end
  end

  assign byp_a = byp[0];
  assign byp_b = byp[1];
  assign en_a  = ctrl[0][0];
  assign en_b  = ctrl[1][0];
  assign win_a = ctrl[0][6:4];
  assign win_b = ctrl[1][6:4];
  assign n_a = cnt[0][0];
  assign m_a = cnt[0][1];
  assign k_a = cnt[0][2];
  assign n_b = cnt[1][0];
  assign m_b = cnt[1][1];
  assign k_b = cnt[1][2];
endmodule

module clkgen_regs_chk #(
  parameter int CNT_W = 19,
  parameter int AW = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_en,
  input logic [AW-1:0]    addr,
  input logic [31:0]      wdata,
  input logic [31:0]      rdata,
  input logic             lock_a,
  input logic             lock_b,
  input logic             byp_a,
  input logic             byp_b,
  input logic             en_a,
  input logic             en_b,
  input logic [2:0]       win_a,
  input logic [2:0]       win_b,
  input logic [CNT_W-1:0] n_a,
  input logic [CNT_W-1:0] m_a,
  input logic [CNT_W-1:0] k_a,
  input logic [CNT_W-1:0] n_b,
  input logic [CNT_W-1:0] m_b,
  input logic [CNT_W-1:0] k_b
);
  assert_reset_bypassed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (byp_a && byp_b && !en_a && !en_b && win_a == 3'd0 && win_b == 3'd0));

  assert_bad_derive_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr[AW-1:2] == 4'd8 && (wdata & ~32'h3000) != 32'h0010)
      |=> ($stable(byp_a) && $stable(byp_b)));

  assert_status_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[AW-1:2] == 4'd9) |-> (rdata[31:6] == 26'd0 && rdata[0] == lock_a &&
      rdata[1] == lock_b && rdata[4] == !byp_a && rdata[5] == !byp_b));

  assert_locked_counts_a_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !byp_a && addr[AW-1:2] < 4'd3) |=> ($stable(n_a) && $stable(m_a) && $stable(k_a)));

  assert_locked_counts_b_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !byp_b && addr[AW-1:2] >= 4'd4 && addr[AW-1:2] < 4'd7)
      |=> ($stable(n_b) && $stable(m_b) && $stable(k_b)));

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (addr[AW-1:2] >= 4'd10) |-> (rdata == 32'd0));
endmodule

bind clkgen_regs clkgen_regs_chk #(.CNT_W(CNT_W), .AW(AW)) u_chk (.*);

// File: tb/sim_clkgen_regs.sv
module sim_clkgen_regs;
  logic clk = 0, rst_n = 0, wr_en = 0, lock_a = 0, lock_b = 0;
  logic [5:0] addr = 0;
  logic [31:0] wdata = 0, rdata;
  logic byp_a, byp_b, en_a, en_b;
  logic [2:0] win_a, win_b;
  logic [18:0] n_a, m_a, k_a, n_b, m_b, k_b;
  int n_chk = 0, n_fail = 0;
  logic rd_vld = 0;
  logic [31:0] exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  clkgen_regs u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] e, input string tag);
    @(negedge clk); addr = a; rd_vld = 1; exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk); rd_vld = 0;
  endtask

  initial forever begin
    @(negedge clk); #2;
    if (rd_vld && exp_q.size() > 0) check(tag_q.pop_front(), rdata, exp_q.pop_front());
  end

  initial begin
    #1000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(6'h20, 32'h3010, "R3 derive after reset");
    @(negedge clk);
    check("R3 bypass outputs", {byp_a, byp_b}, 2'b11);
    rd(6'h0C, 32'h1A04, "R2 ctrl A reset");
    rd(6'h1C, 32'h1A04, "R2 ctrl B reset");
    check("R2 enables off", {en_a, en_b, win_a, win_b}, 0);
    rd(6'h24, 32'h0, "R5 status after reset");
    rd(6'h00, 32'h40000, "R1 count reset");
    wr(6'h00, 32'h20101); wr(6'h04, 32'h20606); wr(6'h08, 32'h10302);
    rd(6'h00, 32'h20101, "R1 A N");
    rd(6'h04, 32'h20606, "R1 A M");
    rd(6'h0B, 32'h10302, "R1 A K low addr bits ignored");
    check("R10 A count outputs", {n_a, m_a, k_a}, {19'h20101, 19'h20606, 19'h10302});
    wr(6'h14, 32'hFFF1_1B1A);
    rd(6'h14, 32'h11B1A, "R1 B M width");
    check("R10 B M output", m_b, 19'h11B1A);
    wr(6'h0C, 32'h1055);
    check("R2 enable/window A", {en_a, win_a}, {1'b1, 3'd5});
    rd(6'h0C, 32'h1055, "R2 ctrl A readback");
    wr(6'h20, 32'h2010);
    check("R4 bypass after 0x2010", {byp_a, byp_b}, 2'b01);
    rd(6'h20, 32'h2010, "R4 derive readback");
    rd(6'h24, 32'h10, "R5 not-bypassed A");
    wr(6'h00, 32'h10302);
    rd(6'h00, 32'h20101, "R8 N write ignored when running");
    check("R8 N output held", n_a, 19'h20101);
    wr(6'h20, 32'h0011);
    rd(6'h20, 32'h2010, "R4 invalid derive ignored");
    wr(6'h20, 32'h3000);
    check("R4 invalid derive outputs", {byp_a, byp_b}, 2'b01);
    @(negedge clk); lock_a = 1;
    rd(6'h24, 32'h15, "R6 lock A rise sets flag");
    wr(6'h24, 32'hFFFF_FFF3);
    rd(6'h24, 32'h15, "R7 zero to flag bit no effect");
    wr(6'h24, 32'h4);
    rd(6'h24, 32'h11, "R7 W1C clears A flag");
    @(negedge clk); lock_b = 1;
    rd(6'h24, 32'h1B, "R6 lock B rise sets flag");
    @(negedge clk); addr = 6'h24; wdata = 32'h8; wr_en = 1; lock_b = 0;
    @(negedge clk); wr_en = 0;
    rd(6'h24, 32'h19, "R7 new change wins over clear");
    wr(6'h24, 32'h8);
    rd(6'h24, 32'h11, "R7 W1C clears B flag");
    @(negedge clk); lock_a = 0;
    rd(6'h24, 32'h14, "R6 lock A fall sets flag");
    wr(6'h20, 32'h0010);
    rd(6'h24, 32'h34, "R5 both not bypassed");
    wr(6'h18, 32'h20202);
    rd(6'h18, 32'h40000, "R8 B K write ignored");
    wr(6'h20, 32'h3010);
    wr(6'h00, 32'h10302);
    rd(6'h00, 32'h10302, "R8 N write accepted when bypassed");
    rd(6'h28, 32'h0, "R9 unmapped 0x28");
    rd(6'h3C, 32'h0, "R9 unmapped 0x3C");
    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule